// File: doc/BRIEF.md
# Nibble Palette Weight Decoder

This block turns a stream of packed 4-bit palette indices into fp16 weights. Each input byte carries two indices. The lower four bits are decoded first and the upper four bits second. Every index selects one of sixteen fp16 entries held in a small codebook. The selected entry goes straight out as the weight: the decoder does no arithmetic, and an index is never read as a signed value.

Software fills the codebook through a write port while the decoder is idle. It then starts a burst by giving an element count. The decoder pulls bytes with a valid/ready handshake and produces at most one weight per cycle on a valid/ready output. When the count is odd, the upper nibble of the final byte is dropped. A one-cycle done pulse closes the burst. Codebook writes made during a burst have no effect, so a new table only applies to bursts that start after done.

Top module: `nib_pal_decoder`

## Requirements
- R1: After reset, out_valid, in_ready, busy and done are all low.
- R2: A write to codebook address A while busy is low stores cb_wdata, and any later index of value A decodes to that entry.
- R3: Within a byte, the index in bits [3:0] is output before the index in bits [7:4]. With entry 0 = 0x0000 and entry 1 = 0x3C00, the bytes 0x01 then 0x10 decode to 0x3C00, 0x0000, 0x0000, 0x3C00.
- R4: A burst started with count N produces exactly N weights, in stream order, and out_valid is low whenever busy is low.
- R5: A new byte is accepted only after every kept index of the previous byte has left the unpacker. A burst of N elements accepts exactly ceil(N/2) bytes, and in_ready is never high outside a burst.
- R6: When N is odd, the index in bits [7:4] of the last byte is discarded and never appears on the output. The next burst starts with a low nibble.
- R7: While out_valid is high and out_ready is low, out_valid stays high and out_data stays unchanged on the next cycle.
- R8: Codebook writes made while busy is high are ignored. A write made in the done cycle is accepted.
- R9: done is high for exactly one cycle. It rises the cycle after the final weight is taken, and busy falls in that same cycle.
- R10: start is ignored while busy is high, and also when elem_count is zero.
- R11: Indices 8 to 15 select codebook entries 8 to 15. They are treated as unsigned indices, not as negative values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cb_we | input | 1 | Codebook write strobe |
| cb_addr | input | 4 | Codebook entry to write |
| cb_wdata | input | 16 | fp16 value to store |
| start | input | 1 | Begin a burst |
| elem_count | input | 16 | Number of weights in the burst |
| in_valid | input | 1 | Packed byte present |
| in_byte | input | 8 | Two packed indices, low nibble first |
| in_ready | output | 1 | Decoder takes in_byte this cycle |
| out_valid | output | 1 | Weight present |
| out_data | output | 16 | Decoded fp16 weight |
| out_ready | input | 1 | Consumer takes out_data |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle end-of-burst pulse |

## Verification
The sharpest collision is a codebook write landing in the same cycle as the hand-off of the final weight. busy is still high in that cycle, so the write must be dropped. One cycle later, in the done cycle, a write must take hold. The bench drives garbage writes on random cycles of every burst, including the final hand-off, and drives a real write exactly in the done cycle. The table values seen by the next burst show which writes were kept. A second overlap is output back-pressure while a byte is waiting at the input. It is provoked by random stalls on both sides and judged by output stability and by the count of emitted weights at each byte acceptance.

// File: rtl/npd_pkg.sv
package npd_pkg;
  localparam int unsigned IDX_W  = 4;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned BYTE_W = 2 * IDX_W;
  localparam int unsigned ENTRIES = 1 << IDX_W;
  typedef logic [WORD_W-1:0] fp16_t;
  typedef logic [IDX_W-1:0]  idx_t;
endpackage

// File: rtl/npd_codebook.sv
module npd_codebook #(
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_data
);
  localparam int unsigned ENTRIES = 1 << IDX_W;

  logic [WORD_W-1:0] entry_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    logic sel;
    assign sel = wr_en && (wr_addr == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   entry_q[g] <= '0;
      else if (sel) entry_q[g] <= wr_data;
    end
  end

  assign rd_data = entry_q[rd_idx];
endmodule

// File: rtl/npd_unpacker.sv
module npd_unpacker #(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [CNT_W-1:0]   count,
  input  logic               active,
  input  logic               in_valid,
  input  logic [2*IDX_W-1:0] in_byte,
  output logic               in_ready,
  input  logic               take,
  output logic               nib_valid,
  output logic [IDX_W-1:0]   nib_idx,
  output logic               nib_last
);
  localparam int unsigned BYTE_W = 2 * IDX_W;

  logic [BYTE_W-1:0] byte_q, byte_d;
  logic              full_q, full_d;
  logic              hi_q, hi_d;
  logic [CNT_W-1:0]  fetch_q, fetch_d;
  logic [CNT_W-1:0]  emit_q, emit_d;
  logic              accept, emit;

  assign in_ready  = active && !full_q && (fetch_q != '0);
  assign accept    = in_valid && in_ready;
  assign nib_valid = full_q;
  assign nib_idx   = hi_q ? byte_q[BYTE_W-1:IDX_W] : byte_q[IDX_W-1:0];
  assign nib_last  = (emit_q == CNT_W'(1));
  assign emit      = full_q && take;

  always_comb begin
    byte_d  = byte_q;
    full_d  = full_q;
    hi_d    = hi_q;
    fetch_d = fetch_q;
    emit_d  = emit_q;
    if (load) begin
      full_d  = 1'b0;
      hi_d    = 1'b0;
      fetch_d = count;
      emit_d  = count;
    end else if (accept) begin
      byte_d  = in_byte;
      full_d  = 1'b1;
      hi_d    = 1'b0;
      fetch_d = (fetch_q >= CNT_W'(2)) ? fetch_q - CNT_W'(2) : '0;
    end else if (emit) begin
      emit_d = emit_q - CNT_W'(1);
      if (hi_q || nib_last) full_d = 1'b0;
      else                  hi_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q  <= '0;
      full_q  <= 1'b0;
      hi_q    <= 1'b0;
      fetch_q <= '0;
      emit_q  <= '0;
    end else begin
      byte_q  <= byte_d;
      full_q  <= full_d;
      hi_q    <= hi_d;
      fetch_q <= fetch_d;
      emit_q  <= emit_d;
    end
  end
endmodule

// File: rtl/npd_out_stage.sv
module npd_out_stage #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_valid,
  input  logic [WORD_W-1:0] src_data,
  input  logic              src_last,
  output logic              slot_free,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  input  logic              out_ready,
  output logic              last_fire
);
  logic              vld_q, vld_d;
  logic [WORD_W-1:0] dat_q, dat_d;
  logic              lst_q, lst_d;
  logic              load;

  assign slot_free = !vld_q || out_ready;
  assign load      = src_valid && slot_free;
  assign last_fire = vld_q && out_ready && lst_q;

  always_comb begin
    vld_d = vld_q;
    dat_d = dat_q;
    lst_d = lst_q;
    if (load) begin
      vld_d = 1'b1;
      dat_d = src_data;
      lst_d = src_last;
    end else if (out_ready) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
      lst_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      dat_q <= dat_d;
      lst_q <= lst_d;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;
endmodule

// File: rtl/nib_pal_decoder.sv
module nib_pal_decoder
  import npd_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cb_we,
  input  logic [IDX_W-1:0]  cb_addr,
  input  logic [WORD_W-1:0] cb_wdata,
  input  logic              start,
  input  logic [CNT_W-1:0]  elem_count,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              in_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  input  logic              out_ready,
  output logic              busy,
  output logic              done
);
  logic  busy_q, busy_d;
  logic  done_q, done_d;
  logic  go;
  logic  slot_free, nib_valid, nib_last, last_fire;
  idx_t  nib_idx;
  fp16_t cb_rd;

  assign go = start && !busy_q && (elem_count != '0);

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    if (go) begin
      busy_d = 1'b1;
    end else if (last_fire) begin
      busy_d = 1'b0;
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  npd_codebook #(.IDX_W(IDX_W), .WORD_W(WORD_W)) u_cb (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cb_we && !busy_q),
    .wr_addr (cb_addr),
    .wr_data (cb_wdata),
    .rd_idx  (nib_idx),
    .rd_data (cb_rd)
  );

  npd_unpacker #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_unp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (go),
    .count     (elem_count),
    .active    (busy_q),
    .in_valid  (in_valid),
    .in_byte   (in_byte),
    .in_ready  (in_ready),
    .take      (slot_free),
    .nib_valid (nib_valid),
    .nib_idx   (nib_idx),
    .nib_last  (nib_last)
  );

  npd_out_stage #(.WORD_W(WORD_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_valid (nib_valid),
    .src_data  (cb_rd),
    .src_last  (nib_last),
    .slot_free (slot_free),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ready (out_ready),
    .last_fire (last_fire)
  );

  assign busy = busy_q;
  assign done = done_q;
endmodule

// File: rtl/npd_checker.sv
module npd_checker #(
  parameter int unsigned WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic [WORD_W-1:0] out_data,
  input logic              out_ready,
  input logic              busy,
  input logic              done
);
  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid); // R7
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_data)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9
  AST_DONE_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(out_valid && out_ready)); // R9
  AST_READY_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> busy); // R5
  AST_NO_OUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !out_valid); // R4
endmodule

bind nib_pal_decoder npd_checker #(.WORD_W(npd_pkg::WORD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_ready (out_ready),
  .busy      (busy),
  .done      (done)
);

// File: tb/nib_pal_decoder_tb.sv
module nib_pal_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cb_we;
  logic [3:0]  cb_addr;
  logic [15:0] cb_wdata;
  logic        start;
  logic [CNT_W-1:0] elem_count;
  logic        in_valid;
  logic [7:0]  in_byte;
  logic        in_ready;
  logic        out_valid;
  logic [15:0] out_data;
  logic        out_ready;
  logic        busy;
  logic        done;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] cb_model [16];
  logic [7:0]  bq [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  nib_pal_decoder #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cb_we(cb_we), .cb_addr(cb_addr),
    .cb_wdata(cb_wdata), .start(start), .elem_count(elem_count),
    .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expect_weight(input int k);
    logic [7:0] b;
    logic [3:0] idx;
    b   = bq[k/2];
    idx = (k % 2 == 1) ? b[7:4] : b[3:0];
    return cb_model[idx];
  endfunction

  task automatic write_cb(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    cb_we = 1'b1; cb_addr = a; cb_wdata = d;
    cb_model[a] = d;
    @(negedge clk);
    cb_we = 1'b0;
  endtask

  // One burst: bq holds the bytes, n the element count.
  task automatic run_burst(input int n, input int stall_pct, input int gap_pct, input bit poke);
    int nb, bi, oi;
    bit got_last, prev_stall;
    logic [15:0] prev_data;
    logic [15:0] exp_w [];
    nb = (n + 1) / 2;
    exp_w = new[n];
    for (int k = 0; k < n; k++) exp_w[k] = expect_weight(k);
    bi = 0; oi = 0; got_last = 0; prev_stall = 0; prev_data = '0;
    @(negedge clk);
    start = 1'b1; elem_count = CNT_W'(n);
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R10 busy after start", busy, 1);
    for (int cyc = 0; cyc < 4000; cyc++) begin
      if (cyc != 0) @(negedge clk);
      if (got_last) begin
        check(done == 1'b1 && busy == 1'b0, "R9 done pulse after last take", {done, busy}, 2'b10);
        in_valid = 1'b0; out_ready = 1'b0; start = 1'b0;
        if (poke) begin
          logic [3:0] a;
          logic [15:0] d;
          a = 4'($urandom); d = 16'($urandom);
          cb_we = 1'b1; cb_addr = a; cb_wdata = d;
          cb_model[a] = d;
        end else cb_we = 1'b0;
        break;
      end
      check(done == 1'b0, "R9 no early done", done, 0);
      if (prev_stall)
        check(out_valid == 1'b1 && out_data == prev_data, "R7 hold under stall", {out_valid, out_data}, {1'b1, prev_data});
      out_ready = ($urandom % 100) >= stall_pct;
      if (bi < nb && (($urandom % 100) >= gap_pct)) begin
        in_valid = 1'b1; in_byte = bq[bi];
      end else begin
        in_valid = 1'b0; in_byte = 8'($urandom);
      end
      cb_we = poke && (($urandom % 3) == 0);
      cb_addr = 4'($urandom); cb_wdata = 16'($urandom);
      start = poke && (($urandom % 5) == 0);
      elem_count = CNT_W'(3);
      #1;
      if (in_valid && in_ready) begin
        // R5: every kept nibble of the earlier bytes has left the unpacker
        check(oi + (out_valid ? 1 : 0) == ((2*bi < n) ? 2*bi : n), "R5 byte taken early",
              oi + (out_valid ? 1 : 0), (2*bi < n) ? 2*bi : n);
        bi++;
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      if (out_valid && out_ready) begin
        if (oi < n) check(out_data == exp_w[oi], "R3 weight order/value", out_data, exp_w[oi]);
        else        check(1'b0, "R4 extra weight", oi, n);
        oi++;
        if (oi == n) got_last = 1;
      end
    end
    @(negedge clk);
    cb_we = 1'b0; start = 1'b0;
    check(oi == n, "R4 weight count", oi, n);
    check(bi == nb, "R5 bytes accepted", bi, nb);
    check(done == 1'b0 && out_valid == 1'b0 && in_ready == 1'b0, "R9 done single cycle",
          {done, out_valid, in_ready}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; cb_we = 0; cb_addr = 0; cb_wdata = 0; start = 0;
    elem_count = 0; in_valid = 0; in_byte = 0; out_ready = 0;
    for (int i = 0; i < 16; i++) cb_model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 0 && in_ready == 0 && busy == 0 && done == 0, "R1 reset state",
          {out_valid, in_ready, busy, done}, 0);

    // R3 worked example
    write_cb(4'd0, 16'h0000);
    write_cb(4'd1, 16'h3C00);
    bq = '{8'h01, 8'h10};
    run_burst(4, 0, 0, 0);

    // R2 / R11: distinct entries, indices 0..15 in order
    for (int i = 0; i < 16; i++) write_cb(4'(i), 16'h4000 + 16'(i * 37));
    bq = '{8'h10, 8'h32, 8'h54, 8'h76, 8'h98, 8'hBA, 8'hDC, 8'hFE};
    run_burst(16, 0, 0, 0);
    bq = '{8'hF8, 8'h9E};
    run_burst(4, 30, 30, 0); // R11 high indices

    // R6: odd count, high nibble of last byte carries a unique marker
    write_cb(4'd15, 16'hDEAD);
    bq = '{8'h21, 8'h43, 8'hF5};
    run_burst(5, 20, 20, 0);
    bq = '{8'h76, 8'h98};
    run_burst(3, 0, 0, 0); // R6 next burst starts at low nibble

    // R10: zero count start is ignored
    @(negedge clk);
    start = 1'b1; elem_count = '0;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b0 && in_ready == 1'b0, "R10 zero count ignored", {busy, in_ready}, 0);

    // R8 / R10: random bursts with writes and starts poked in mid-burst
    for (int t = 0; t < 40; t++) begin
      int n;
      n = 1 + ($urandom % 40);
      bq.delete();
      for (int k = 0; k < (n + 1) / 2; k++) bq.push_back(8'($urandom));
      run_burst(n, $urandom % 60, $urandom % 60, 1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule